// File: doc/BRIEF.md
# Pointer Bounds Register File and Range Checker

This block keeps a small file of pointer-bounds registers and tests addresses against them. Each entry pairs a lower limit with an upper limit. The upper limit is always held inverted, as its ones' complement. A build command fills an entry from a base address and a byte count. Two check commands then compare an address against one selected entry, one for the low side and one for the high side. A failed check raises a single-cycle fault.

The first fault also freezes the failing address and a reason code in a status holder, and that record stays until software clears it. Two enable bits gate every command: one for user privilege and one for kernel privilege. The current privilege input picks which bit applies. Commands are taken one per cycle with no handshake. A read port shows any entry's contents, with the upper field in its stored, inverted form.

A small state machine drives the fault and status side. It has three states:
- `ST_IDLE` means no record is held.
- `ST_TRAP` is the cycle in which a fault is reported.
- `ST_HELD` means a record is held and no fault is being reported.

The transitions are:
- IDLE→TRAP and HELD→TRAP on a failed check.
- TRAP→TRAP when faults come back to back.
- TRAP→HELD when no new fault arrives and no clear is given.
- TRAP→IDLE and HELD→IDLE on a clear with no fault.
- IDLE→IDLE and HELD→HELD otherwise.

Top module: `bnd_unit`

## Requirements
- R1: After reset, every entry reads lower = 0 and stored upper = 0 (an effective upper limit of all ones). Both enable bits are 0, `stat_valid` is 0 and `fault` is 0.
- R2: An enabled build command (`cmd_op` = 1) writes lower = `cmd_addr` and stored upper = ~(`cmd_addr` + `cmd_size` − 1) modulo 2^64 into entry `cmd_reg`. The new values are visible on the read port after the sampling clock edge.
- R3: An enabled low check (`cmd_op` = 2) fails when `cmd_addr` < lower, compared unsigned, and reports code 1. An address equal to lower passes.
- R4: An enabled high check (`cmd_op` = 3) fails when `cmd_addr` > ~stored upper, compared unsigned, and reports code 2. An address equal to the limit passes.
- R5: `fault` is high for exactly the one cycle after each failing command's sampling edge. Two failing commands back to back give two consecutive high cycles.
- R6: A failure while no record is held sets `stat_valid` and latches `stat_addr` = the failing address and `stat_code` = the reason code.
- R7: While a record is held, later failures still pulse `fault` but leave `stat_addr` and `stat_code` unchanged. `stat_clr` drops `stat_valid`. A failure in the same cycle as `stat_clr` is recorded as the new record.
- R8: `cfg_wr` writes `cfg_en` into the user enable (`cfg_sel` = 0) or the kernel enable (`cfg_sel` = 1). `priv_kern` = 1 selects the kernel bit and `priv_kern` = 0 selects the user bit.
- R9: When the selected enable bit is 0, build and check commands change no entry and raise no fault.
- R10: A command with `cmd_op` = 0 (no-op) changes nothing and raises no fault.
- R11: A build with size 0 gives an upper limit of base − 1, so a high check at the base itself fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 no-op, 1 build, 2 low check, 3 high check |
| cmd_reg | input | 2 | Selected bounds entry |
| cmd_addr | input | 64 | Base address (build) or address under test (check) |
| cmd_size | input | 64 | Byte count for build |
| priv_kern | input | 1 | 1 = kernel privilege, 0 = user |
| cfg_wr | input | 1 | Enable-bit write strobe |
| cfg_sel | input | 1 | 0 = user enable, 1 = kernel enable |
| cfg_en | input | 1 | Value written to the enable bit |
| stat_clr | input | 1 | Clear the held status record |
| rd_reg | input | 2 | Entry shown on the read port |
| rd_lower | output | 64 | Lower limit of entry `rd_reg` |
| rd_upper_raw | output | 64 | Stored, inverted upper limit of entry `rd_reg` |
| fault | output | 1 | Bound-range fault pulse |
| stat_valid | output | 1 | A status record is held |
| stat_addr | output | 64 | Failing address of the held record |
| stat_code | output | 2 | 1 low violation, 2 high violation |
| cfg_user_en | output | 1 | User enable bit |
| cfg_kern_en | output | 1 | Kernel enable bit |

## Verification
A command sampled at one rising edge shows its effects right after that edge. A build updates the read port after that edge, and the read port is combinational. A failing check raises `fault` for the following cycle and updates the status record at the same edge. The driver task pushes the expected fault bit when it releases the sampling edge. The monitor pops that bit on the next falling edge, so every fault comparison lands mid-cycle, exactly one register stage after the command. Status, enable and read-port values are compared one nanosecond after the sampling edge.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_MAKE = 2'd1,
        OP_CHKL = 2'd2,
        OP_CHKU = 2'd3
    } bnd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRAP = 2'd1,
        ST_HELD = 2'd2
    } bnd_st_e;

    localparam logic [1:0] ERR_LOW  = 2'd1;
    localparam logic [1:0] ERR_HIGH = 2'd2;
endpackage

// File: rtl/bnd_regfile.sv
module bnd_regfile #(
    parameter int NREG = 4,
    parameter int AW   = 64,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [RW-1:0]             wr_idx,
    input  logic [AW-1:0]             wr_lo,
    input  logic [AW-1:0]             wr_hi_n,
    output logic [NREG-1:0][AW-1:0]   lo_q,
    output logic [NREG-1:0][AW-1:0]   hi_n_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g]   <= '0;
                hi_n_q[g] <= '0;
            end else if (wr_en && wr_idx == RW'(g)) begin
                lo_q[g]   <= wr_lo;
                hi_n_q[g] <= wr_hi_n;
            end
        end
    end
endmodule

// File: rtl/bnd_cmp.sv
module bnd_cmp #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi_n,
    output logic          below,
    output logic          above
);
    logic [AW-1:0] hi_lim;

    always_comb begin
        hi_lim = ~hi_n;
        below  = addr < lo;
        above  = addr > hi_lim;
    end
endmodule

// File: rtl/bnd_ctrl.sv
module bnd_ctrl
    import bnd_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_lo,
    input  logic          hit_hi,
    input  logic [AW-1:0] addr,
    input  logic          stat_clr,
    output logic          fault,
    output logic          stat_valid,
    output logic [AW-1:0] stat_addr,
    output logic [1:0]    stat_code
);
    bnd_st_e state, state_nx;
    logic    hit;
    logic    capture;

    always_comb begin
        hit      = hit_lo || hit_hi;
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = hit ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_nx = hit ? ST_TRAP : (stat_clr ? ST_IDLE : ST_HELD);
            ST_HELD: state_nx = hit ? ST_TRAP : (stat_clr ? ST_IDLE : ST_HELD);
            default: state_nx = ST_IDLE;
        endcase
        capture = hit && (state == ST_IDLE || stat_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_addr <= '0;
            stat_code <= '0;
        end else if (capture) begin
            stat_addr <= addr;
            stat_code <= hit_lo ? ERR_LOW : ERR_HIGH;
        end
    end

    always_comb begin
        fault      = (state == ST_TRAP);
        stat_valid = (state != ST_IDLE);
    end
endmodule

// File: rtl/bnd_unit.sv
module bnd_unit
    import bnd_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 64,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [RW-1:0] cmd_reg,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cmd_size,
    input  logic          priv_kern,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic          cfg_en,
    input  logic          stat_clr,
    input  logic [RW-1:0] rd_reg,
    output logic [AW-1:0] rd_lower,
    output logic [AW-1:0] rd_upper_raw,
    output logic          fault,
    output logic          stat_valid,
    output logic [AW-1:0] stat_addr,
    output logic [1:0]    stat_code,
    output logic          cfg_user_en,
    output logic          cfg_kern_en
);
    logic [NREG-1:0][AW-1:0] lo_q, hi_n_q;
    bnd_op_e       op;
    logic          go, mk, below, above, hit_lo, hit_hi;
    logic [AW-1:0] mk_hi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_user_en <= 1'b0;
            cfg_kern_en <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_sel) cfg_kern_en <= cfg_en;
            else         cfg_user_en <= cfg_en;
        end
    end

    always_comb begin
        op      = bnd_op_e'(cmd_op);
        go      = cmd_valid && (priv_kern ? cfg_kern_en : cfg_user_en);
        mk      = go && (op == OP_MAKE);
        mk_hi_n = ~(cmd_addr + cmd_size - AW'(1));
        hit_lo  = go && (op == OP_CHKL) && below;
        hit_hi  = go && (op == OP_CHKU) && above;
    end

    bnd_regfile #(.NREG(NREG), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mk),
        .wr_idx  (cmd_reg),
        .wr_lo   (cmd_addr),
        .wr_hi_n (mk_hi_n),
        .lo_q    (lo_q),
        .hi_n_q  (hi_n_q)
    );

    bnd_cmp #(.AW(AW)) u_cmp (
        .addr  (cmd_addr),
        .lo    (lo_q[cmd_reg]),
        .hi_n  (hi_n_q[cmd_reg]),
        .below (below),
        .above (above)
    );

    bnd_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_lo     (hit_lo),
        .hit_hi     (hit_hi),
        .addr       (cmd_addr),
        .stat_clr   (stat_clr),
        .fault      (fault),
        .stat_valid (stat_valid),
        .stat_addr  (stat_addr),
        .stat_code  (stat_code)
    );

    always_comb begin
        rd_lower     = lo_q[rd_reg];
        rd_upper_raw = hi_n_q[rd_reg];
    end
endmodule

// File: rtl/bnd_unit_chk.sv
module bnd_unit_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          priv_kern,
    input logic          cfg_user_en,
    input logic          cfg_kern_en,
    input logic          stat_clr,
    input logic          fault,
    input logic          stat_valid,
    input logic [AW-1:0] stat_addr,
    input logic [1:0]    stat_code
);
    logic en_w;
    assign en_w = priv_kern ? cfg_kern_en : cfg_user_en;

    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(cmd_valid && en_w && cmd_op[1]));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !en_w) |=> !fault);

    // R6
    fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> stat_valid);

    // R6
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_code == 2'd1 || stat_code == 2'd2));

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && $past(stat_valid) && !$past(stat_clr))
            |-> ($stable(stat_addr) && $stable(stat_code)));

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(cmd_valid && cmd_op[1])) |=> !stat_valid);
endmodule

bind bnd_unit bnd_unit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .priv_kern   (priv_kern),
    .cfg_user_en (cfg_user_en),
    .cfg_kern_en (cfg_kern_en),
    .stat_clr    (stat_clr),
    .fault       (fault),
    .stat_valid  (stat_valid),
    .stat_addr   (stat_addr),
    .stat_code   (stat_code)
);

// File: tb/bnd_unit_test.sv
`timescale 1ns/1ps
module bnd_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_reg = 2'd0;
    logic [63:0] cmd_addr = '0;
    logic [63:0] cmd_size = '0;
    logic        priv_kern = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_en = 1'b0;
    logic        stat_clr = 1'b0;
    logic [1:0]  rd_reg = 2'd0;
    logic [63:0] rd_lower, rd_upper_raw, stat_addr;
    logic        fault, stat_valid, cfg_user_en, cfg_kern_en;
    logic [1:0]  stat_code;

    int  total = 0;
    int  bad = 0;
    bit  started = 1'b0;
    bit  finished = 1'b0;
    bit  exp_q[$];

    always #2 clk = ~clk;

    bnd_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .priv_kern(priv_kern), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_en(cfg_en), .stat_clr(stat_clr), .rd_reg(rd_reg),
        .rd_lower(rd_lower), .rd_upper_raw(rd_upper_raw), .fault(fault),
        .stat_valid(stat_valid), .stat_addr(stat_addr), .stat_code(stat_code),
        .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one command per call, expected fault bit pushed at its sampling edge
    task automatic cmd(input logic [1:0] op, input logic [1:0] r, input logic [63:0] a,
                       input logic [63:0] s, input bit ef, input bit clr = 1'b0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_addr = a; cmd_size = s;
        stat_clr = clr;
        @(posedge clk);
        exp_q.push_back(ef);
        #1;
        cmd_valid = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic cfg(input bit sel, input bit en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_en = en;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] r, input string tag,
                      input logic [63:0] elo, input logic [63:0] ehi);
        rd_reg = r;
        #0.5;
        chk({tag, " lower"}, rd_lower, elo);
        chk({tag, " upper"}, rd_upper_raw, ehi);
    endtask

    // monitor: fault must match the queued expectation, else stay low
    always @(negedge clk) begin
        if (started) begin
            bit e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            chk("R5 fault pulse", {63'd0, fault}, {63'd0, e});
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(2'(i), "R1 reset", 64'd0, 64'd0);
        chk("R1 stat_valid", {63'd0, stat_valid}, 64'd0);
        chk("R1 fault", {63'd0, fault}, 64'd0);
        chk("R1 enables", {62'd0, cfg_user_en, cfg_kern_en}, 64'd0);
        started = 1'b1;

        // R9 build while disabled does nothing
        cmd(2'd1, 2'd1, 64'h1000, 64'h100, 1'b0);
        rd(2'd1, "R9 disabled build", 64'd0, 64'd0);

        // R8 enable write for user mode
        cfg(1'b0, 1'b1);
        chk("R8 user en", {63'd0, cfg_user_en}, 64'd1);
        chk("R8 kern en", {63'd0, cfg_kern_en}, 64'd0);

        // R2 build
        cmd(2'd1, 2'd1, 64'h1000, 64'h100, 1'b0);
        rd(2'd1, "R2 build", 64'h1000, ~64'h10FF);

        // R3 low check boundary and violation, R6 capture
        cmd(2'd2, 2'd1, 64'h1000, 64'd0, 1'b0);
        cmd(2'd2, 2'd1, 64'h0FFF, 64'd0, 1'b1);
        chk("R6 valid", {63'd0, stat_valid}, 64'd1);
        chk("R6 addr", stat_addr, 64'h0FFF);
        chk("R3 code", {62'd0, stat_code}, 64'd1);

        // R4 high check boundary and violation, R7 record held
        cmd(2'd3, 2'd1, 64'h10FF, 64'd0, 1'b0);
        cmd(2'd3, 2'd1, 64'h1100, 64'd0, 1'b1);
        chk("R7 held addr", stat_addr, 64'h0FFF);
        chk("R7 held code", {62'd0, stat_code}, 64'd1);

        // R7 clear
        cmd(2'd0, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1);
        chk("R7 cleared", {63'd0, stat_valid}, 64'd0);

        // R5 back-to-back faults; R4 code
        cmd(2'd3, 2'd1, 64'h2000, 64'd0, 1'b1);
        cmd(2'd2, 2'd1, 64'h10, 64'd0, 1'b1);
        chk("R4 addr", stat_addr, 64'h2000);
        chk("R4 code", {62'd0, stat_code}, 64'd2);

        // R7 fault in same cycle as clear is recorded
        cmd(2'd2, 2'd1, 64'h20, 64'd0, 1'b1, 1'b1);
        chk("R7 clr+fault addr", stat_addr, 64'h20);
        chk("R7 clr+fault code", {62'd0, stat_code}, 64'd1);
        cmd(2'd0, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1);

        // R9 kernel mode with kernel enable clear
        priv_kern = 1'b1;
        cmd(2'd2, 2'd1, 64'd0, 64'd0, 1'b0);
        chk("R9 no record", {63'd0, stat_valid}, 64'd0);
        cmd(2'd1, 2'd2, 64'h5000, 64'h10, 1'b0);
        rd(2'd2, "R9 kernel build", 64'd0, 64'd0);
        priv_kern = 1'b0;

        // R10 no-op command
        cmd(2'd0, 2'd1, 64'd0, 64'd0, 1'b0);
        rd(2'd1, "R10 no-op", 64'h1000, ~64'h10FF);
        chk("R10 no record", {63'd0, stat_valid}, 64'd0);

        // R11 zero size
        cmd(2'd1, 2'd3, 64'h2000, 64'd0, 1'b0);
        rd(2'd3, "R11 zero size", 64'h2000, ~64'h1FFF);
        cmd(2'd3, 2'd3, 64'h2000, 64'd0, 1'b1);
        chk("R11 code", {62'd0, stat_code}, 64'd2);
        cmd(2'd0, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1);

        // R3/R4 unsigned compares at top of range
        cmd(2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FF00, 64'h100, 1'b0);
        rd(2'd0, "R2 top build", 64'hFFFF_FFFF_FFFF_FF00, 64'd0);
        cmd(2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
        cmd(2'd2, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
        chk("R3 unsigned code", {62'd0, stat_code}, 64'd1);
        cmd(2'd0, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1);

        // R8 kernel enable selected by privilege
        cfg(1'b1, 1'b1);
        chk("R8 kern en set", {63'd0, cfg_kern_en}, 64'd1);
        priv_kern = 1'b1;
        cmd(2'd2, 2'd0, 64'h10, 64'd0, 1'b1);
        chk("R8 kernel check", stat_addr, 64'h10);

        repeat (3) @(negedge clk);
        chk("R5 queue drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule